// File: doc/BRIEF.md
# Two-of-Three Serial Bit Detector

This block watches a serial bit stream, one bit per clock on the cycles where its valid strobe is high. It raises its detect output whenever the bit arriving now, together with the two accepted bits before it, holds exactly two ones. A window of three ones gives no detect, and neither does a window with one one or with none.

After reset the block counts nothing as seen. The first two accepted bits only fill the history, and detect stays low for both of them. The earliest detect can come with the third accepted bit. The state is three register bits. They record how full the history is and the last two accepted bits. The current bit completes the three-bit window through combinational logic, so detect belongs to the same cycle as the bit that completes the window.

A typical use is as a small pattern qualifier behind a serialiser or sampler. Idle cycles, with valid low, can appear anywhere in the stream and do not disturb it.

Top module: `tot_detect`

## Requirements
- R1: While valid is high and at least two bits were accepted before this one, detect is 1 exactly when the window {second-previous, previous, current} holds two ones.
- R2: A window of three ones gives detect 0. So does a window of one one or of none.
- R3: The first and second bits accepted after reset never raise detect, whatever their values.
- R4: Detect is combinational and belongs to the cycle of the completing bit. It is 0 in every cycle where valid is low.
- R5: Cycles with valid low leave the history and the fill level unchanged. The bits accepted before and after a gap form the window as if there were no gap.
- R6: An active-low reset clears the machine to the empty state at once and holds detect at 0. Its release passes through a two-stage synchroniser, so bits offered in the first two clock edges after release are not accepted.
- R7: Once full, the machine tells all eight three-bit windows 000 to 111 apart. Only 011, 101 and 110 give detect 1. The state fits in three register bits; the code 3'b001 is never reached.
- R8: The accepted stream 0,1,1,0,1,1,1,0,0 gives detect 0,0,1,1,1,1,0,1,0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | High when in_bit carries a bit to accept this cycle |
| in_bit | input | 1 | Serial data bit |
| detect | output | 1 | High when the window completed by this bit holds exactly two ones |

## Verification
Detect is due in the same cycle as the bit that completes the window, with no register between input and output. The bench therefore applies each bit one time unit after a rising edge and reads detect at the next falling edge, before the edge that absorbs the bit. The history register changes on that rising edge, so the next bit's result reflects it at the following falling edge. After reset is released the bench holds valid low for several cycles, which covers the two synchroniser edges. It expects nothing to be accepted until that point.

// File: rtl/tot_pkg.sv
package tot_pkg;
  localparam int WIN_LEN   = 3;
  localparam int HIST_LEN  = WIN_LEN - 1;
  localparam int ST_W      = 3;
  localparam int HIT_ONES  = 2;
  localparam int CNT_W     = $clog2(WIN_LEN + 1);

  // bit2: history full; bit1: one bit seen; low bits: recent bits (older first)
  typedef enum logic [ST_W-1:0] {
    ST_EMPTY = 3'b000,
    ST_SEEN0 = 3'b010,
    ST_SEEN1 = 3'b011,
    ST_H00   = 3'b100,
    ST_H01   = 3'b101,
    ST_H10   = 3'b110,
    ST_H11   = 3'b111
  } tot_state_e;

  localparam logic [ST_W-1:0] ST_UNUSED = 3'b001;
endpackage

// File: rtl/tot_rst_sync.sv
module tot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/tot_next.sv
module tot_next
  import tot_pkg::*;
(
  input  tot_state_e state_cur,
  input  logic       bit_valid,
  input  logic       bit_val,
  output tot_state_e state_nxt
);
  always_comb begin
    state_nxt = state_cur;
    if (bit_valid) begin
      case (state_cur)
        ST_EMPTY: state_nxt = bit_val ? ST_SEEN1 : ST_SEEN0;
        ST_SEEN0, ST_SEEN1,
        ST_H00, ST_H01, ST_H10, ST_H11:
          state_nxt = tot_state_e'({1'b1, state_cur[0], bit_val});
        default:  state_nxt = ST_EMPTY;
      endcase
    end
  end
endmodule

// File: rtl/tot_eval.sv
module tot_eval
  import tot_pkg::*;
(
  input  tot_state_e state_cur,
  input  logic       bit_valid,
  input  logic       bit_val,
  output logic       hit
);
  logic [WIN_LEN-1:0] window;
  logic [CNT_W-1:0]   ones;
  logic               full;

  assign full   = state_cur[ST_W-1];
  assign window = {state_cur[HIST_LEN-1:0], bit_val};

  always_comb begin
    ones = '0;
    for (int i = 0; i < WIN_LEN; i++) begin
      ones = ones + CNT_W'(window[i]);
    end
  end

  assign hit = bit_valid & full & (ones == CNT_W'(HIT_ONES));
endmodule

// File: rtl/tot_detect.sv
module tot_detect
  import tot_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_bit,
  output logic detect
);
  logic       rst_q;
  tot_state_e state_q;
  tot_state_e state_d;

  tot_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q)
  );

  tot_next u_next (
    .state_cur (state_q),
    .bit_valid (in_valid),
    .bit_val   (in_bit),
    .state_nxt (state_d)
  );

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      state_q <= ST_EMPTY;
    end else if (in_valid) begin
      state_q <= state_d;
    end
  end

  tot_eval u_eval (
    .state_cur (state_q),
    .bit_valid (in_valid),
    .bit_val   (in_bit),
    .hit       (detect)
  );

  // R1
  window_match_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && state_q[ST_W-1]) |->
      (detect == ($countones({state_q[HIST_LEN-1:0], in_bit}) == HIT_ONES)));

  // R2
  all_ones_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && state_q == ST_H11 && in_bit) |-> !detect);

  // R3
  fill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (!state_q[ST_W-1]) |-> !detect);

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |-> !detect);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> $stable(state_q));

  // R7
  state_legal_chk: assert property (@(posedge clk) disable iff (!rst_q)
    state_q != ST_UNUSED);
endmodule

// File: tb/tot_detect_tb_top.sv
`timescale 1ns/1ps
module tot_detect_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic detect;

  typedef struct {
    logic  exp;
    string req;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails = 0;
  int model_cnt = 0;
  logic [1:0] model_hist = 2'b00;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tot_detect dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_bit   (in_bit),
    .detect   (detect)
  );

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: detect=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic v, input logic b, input string req);
    item_t it;
    int ones;
    @(posedge clk);
    #1;
    in_valid = v;
    in_bit   = b;
    if (v && rst_n) begin
      ones   = int'(model_hist[1]) + int'(model_hist[0]) + int'(b);
      it.exp = (model_cnt >= 2) && (ones == 2);
      it.req = req;
      q.push_back(it);
      model_hist = {model_hist[0], b};
      if (model_cnt < 3) model_cnt++;
    end
  endtask

  task automatic do_reset(input int cycles);
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    model_cnt = 0;
    model_hist = 2'b00;
    // R6: ones offered while in reset must not raise detect
    for (int i = 0; i < cycles; i++) drive(1'b1, 1'b1, "R6");
    drive(1'b0, 1'b0, "R6");
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) drive(1'b0, 1'b0, "R6");
  endtask

  task automatic send_stream(input logic [15:0] bits, input int n, input string req);
    for (int i = n - 1; i >= 0; i--) drive(1'b1, bits[i], req);
  endtask

  // monitor / scoreboard
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        check(detect, 1'b0, "R6");
      end else if (in_valid) begin
        if (q.size() == 0) begin
          check(detect, 1'bx, "R1 (no expected item)");
        end else begin
          it = q.pop_front();
          check(detect, it.exp, it.req);
        end
      end else begin
        check(detect, 1'b0, "R4");
      end
    end
  end

  initial begin
    do_reset(3);
    // R8: reference stream 011011100 -> 001111010
    send_stream(16'b0000_0000_1101_1100, 9, "R8");
    // R3: new reset, first two accepted ones stay quiet, third completes 110
    do_reset(2);
    send_stream(16'b0000_0000_0000_0110, 3, "R3");
    // R2: runs of ones and zeros
    send_stream(16'b0000_0000_0111_1000, 7, "R2");
    // R7: de Bruijn-style walk through all eight windows
    do_reset(1);
    send_stream(16'b0000_0000_1110_1000, 10, "R7");
    // R5: gaps between accepted bits do not disturb the window
    do_reset(1);
    drive(1'b1, 1'b1, "R5");
    drive(1'b0, 1'b1, "R5");
    drive(1'b0, 1'b0, "R5");
    drive(1'b1, 1'b0, "R5");
    for (int i = 0; i < 3; i++) drive(1'b0, 1'b1, "R5");
    drive(1'b1, 1'b1, "R5");
    drive(1'b0, 1'b1, "R5");
    drive(1'b1, 1'b1, "R5");
    // R1: mixed stream with idles
    drive(1'b1, 1'b0, "R1");
    drive(1'b0, 1'b0, "R1");
    drive(1'b1, 1'b1, "R1");
    drive(1'b1, 1'b0, "R1");
    drive(1'b1, 1'b1, "R1");
    drive(1'b0, 1'b0, "R1");
    repeat (3) @(negedge clk);
    if (q.size() != 0) check(1'b0, 1'b1, "R1 (items left)");
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule